// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request port and an external asynchronous static RAM of 64K words by 16 bits. A requester presents a read or write with an address, write data and two byte-enable bits under a valid/ready handshake. The controller turns each accepted request into one timed access on the memory pins. Chip select, output enable, write strobe and the two lane selects are all active low. The data bus is split into a drive value, a drive enable and a sampled input. Reads end with a one-cycle valid pulse that carries the data and the set of lanes that took part.

Every memory timing limit is a parameter in nanoseconds, alongside the clock period. The cycle counts for the read window, the write strobe and the bus turnaround are computed from them by rounding up. One controller can then be built for either speed grade at any clock rate.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, chip select, output enable, write strobe and both lane selects are high, the bus driver is off, `rd_valid` is low and `req_ready` is high.
- R2: A read holds chip select and output enable low and the write strobe high for exactly RD_CYC cycles. It then returns the sampled data on `rd_data` with a `rd_valid` pulse that lasts one cycle.
- R3: Request byte-enable bit 0 selects the low lane (data bits 7:0) and drives `mem_lb_n` low. Bit 1 selects the high lane (bits 15:8) and drives `mem_ub_n` low. On a read, a lane that was not selected returns zero, and `rd_lanes` repeats the enable bits of that read.
- R4: A write holds chip select and the write strobe low for WR_CYC cycles with the data driven throughout. Only the selected lanes change in memory. The bus is driven only while the write strobe and chip select are low.
- R5: Address, lane selects and drive data stay constant from the first to the last cycle of an access.
- R6: `req_ready` is low in every cycle in which chip select is low, so an access takes exactly one request.
- R7: After a read ends, the bus is not driven again until at least TA_CYC cycles after output enable has gone high. A write request is held off (`req_ready` low) during that window.
- R8: With both byte-enable bits zero, a write changes no memory content, and a read returns zero data with `rd_lanes` equal to 0.
- R9: Output enable and the write strobe are never low in the same cycle.
- R10: RD_CYC is the largest of ceil(cycle time / clock period), ceil(output-enable access / clock period) and 1. WR_CYC is the largest of the ceilings of cycle time, write pulse width, address-to-end-of-write and data setup. TA_CYC is ceil(output-disable time / clock period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| rd_lanes | output | 2 | Lanes that took part in the returned read |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | High-lane select, active low |
| mem_lb_n | output | 1 | Low-lane select, active low |
| mem_dq_out | output | 16 | Bus drive value |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Sampled bus value |

## Verification
The bench's memory model puts a junk byte on the bus until the output-enable window has lasted the full computed read time. It puts the same junk byte on every lane that was not selected. A controller that samples one cycle early, or that fails to zero an unselected lane, therefore returns that pattern where the scoreboard expects real data. Single-lane writes are followed by full-word reads, so writing the wrong lane or a lane that was not selected shows up as a corrupted neighbour byte. The same applies to a write with no lanes selected. Reads followed directly by writes exercise the turnaround window: a controller that drives the bus too soon after output enable rises is counted by the model's bus-contention check. The pseudo-random access stream also tracks strobe widths, address stability and overlap of output enable with the write strobe.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SRAM lane controller.
// Assumes: helper functions are used only with positive divisors.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    // Ceiling division of nanoseconds by the clock period.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request at a time, times the read window
// or write strobe, and holds off writes during the post-read turnaround.
// Assumes: RD_CYC and WR_CYC are at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic acc,
    output logic fin,
    output logic fin_rd
);

    localparam int MAX_CYC = max_of(RD_CYC, WR_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int TA_W    = $clog2(TA_CYC + 2);

    phase_t             phase;
    logic [CNT_W-1:0]   left;
    logic [TA_W-1:0]    ta_left;
    logic               hold_wr;

    // Handshake and end-of-access decode.
    always_comb begin
        hold_wr   = (ta_left != '0) && req_write;
        req_ready = (phase == PH_IDLE) && !hold_wr;
        acc       = req_valid && req_ready;
        fin       = (phase != PH_IDLE) && (left == '0);
        fin_rd    = fin && (phase == PH_READ);
    end

    // Phase and cycle counter of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            left  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (acc) begin
                        phase <= req_write ? PH_WRITE : PH_READ;
                        left  <= req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                    end
                end
                default: begin
                    if (left == '0) phase <= PH_IDLE;
                    else            left  <= left - 1'b1;
                end
            endcase
        end
    end

    // Turnaround window started when a read releases output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)              ta_left <= '0;
        else if (fin_rd)         ta_left <= TA_W'(TA_CYC);
        else if (ta_left != '0)  ta_left <= ta_left - 1'b1;
    end

endmodule

// File: rtl/sram_pins.sv
`timescale 1ns/1ps
// Pin driver: registers address, lane selects, strobes and bus drive for
// the whole access so no pin changes between acceptance and the end.
// Assumes: acc and fin never occur in the same cycle.
module sram_pins #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              fin,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [1:0]        lanes
);

    // Control pins: set on acceptance, released at the end of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else if (acc) begin
            mem_ce_n  <= 1'b0;
            mem_oe_n  <= req_write;
            mem_we_n  <= !req_write;
            mem_ub_n  <= !req_be[1];
            mem_lb_n  <= !req_be[0];
            mem_dq_oe <= req_write;
        end else if (fin) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end
    end

    // Address, data and lane record: captured once per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            lanes      <= '0;
        end else if (acc) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            lanes      <= req_be;
        end
    end

endmodule

// File: rtl/sram_rdcap.sv
`timescale 1ns/1ps
// Read capture: samples the bus in the last cycle of the read window,
// zeroes unselected lanes and raises a one-cycle valid strobe.
// Assumes: DATA_W is even, split into two equal lanes.
module sram_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_rd,
    input  logic [1:0]        lanes,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_lanes
);

    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        // Keep a lane only if it was selected.
        assign masked[g*LANE_W +: LANE_W] = lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end

    // Result registers and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_lanes <= '0;
        end else begin
            rd_valid <= fin_rd;
            if (fin_rd) begin
                rd_data  <= masked;
                rd_lanes <= lanes;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
// Top: clocked request port to asynchronous 16-bit SRAM with lane selects.
// Timing limits are given in ns and turned into cycle counts by rounding up.
// Assumes: requester holds request fields steady while req_valid is high.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 10,
    parameter int T_CYCLE_NS = 15,
    parameter int T_WP_NS    = 10,
    parameter int T_AW_NS    = 10,
    parameter int T_DS_NS    = 7,
    parameter int T_OE_NS    = 7,
    parameter int T_OHZ_NS   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_lanes,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC = max_of(max_of(ceil_div(T_CYCLE_NS, CLK_NS),
                                          ceil_div(T_OE_NS, CLK_NS)), 1);
    localparam int WR_CYC = max_of(max_of(ceil_div(T_CYCLE_NS, CLK_NS),
                                          ceil_div(T_WP_NS, CLK_NS)),
                                   max_of(ceil_div(T_AW_NS, CLK_NS),
                                          max_of(ceil_div(T_DS_NS, CLK_NS), 1)));
    localparam int TA_CYC = ceil_div(T_OHZ_NS, CLK_NS);

    logic       acc, fin, fin_rd;
    logic [1:0] lanes;

    sram_seq #(
        .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .acc(acc), .fin(fin), .fin_rd(fin_rd)
    );

    sram_pins #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .acc(acc), .fin(fin), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .lanes(lanes)
    );

    sram_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk(clk), .rst_n(rst_n), .fin_rd(fin_rd), .lanes(lanes), .dq_in(mem_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_lanes(rd_lanes)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_lane_ctrl: strobe widths, turnaround, pin
// stability and handshake rules. Bound to every instance of the top.
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);

    int unsigned we_run, oe_run, oe_off;

    // Run lengths of strobes and cycles since output enable released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= 0;
            oe_run <= 0;
            oe_off <= TA_CYC;
        end else begin
            we_run <= mem_we_n ? 0 : we_run + 1;
            oe_run <= mem_oe_n ? 0 : oe_run + 1;
            if (!mem_oe_n)            oe_off <= 0;
            else if (oe_off < TA_CYC) oe_off <= oe_off + 1;
        end
    end

    a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r4_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

    a_r5_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r2_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= WR_CYC));

    a_r10_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run >= RD_CYC));

    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_off >= TA_CYC));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected reads, a monitor pops and
// compares them; a behavioural memory model enforces the timing limits.
module sim_sram_lane_ctrl;

    localparam int CLK_NS = 5;
    // Expected cycle counts from the requirement (R10), for 5 ns clock.
    localparam int RD_EXP = 3;   // max(ceil(15/5), ceil(7/5), 1)
    localparam int WR_EXP = 3;   // max(ceil(15/5), ceil(10/5), ceil(10/5), ceil(7/5))
    localparam int TA_EXP = 2;   // ceil(7/5)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [1:0]  rd_lanes;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .rd_lanes(rd_lanes),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] model_mem [int];
    int          oe_run = 0, we_run = 0, oe_off = 100;
    int          v_stable = 0, v_ready = 0, v_excl = 0, v_drive = 0;
    int          v_rdw = 0, v_wp = 0, v_turn = 0;
    logic        p_ce_n = 1, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0, p_ub_n = 1, p_lb_n = 1;
    logic [15:0] p_addr = '0, p_dq = '0;

    function automatic logic [15:0] mget(input int a);
        return model_mem.exists(a) ? model_mem[a] : 16'h0000;
    endfunction

    // Bus from the memory: junk until the read window is long enough,
    // junk on unselected lanes.
    always_comb begin
        mem_dq_in = 16'hEEEE;
        if (!mem_ce_n && mem_we_n && !mem_oe_n && oe_run >= RD_EXP) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = mget(int'(mem_addr)) [7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = mget(int'(mem_addr)) [15:8];
        end
    end

    // Model bookkeeping and timing checks, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && !p_ce_n &&
                (mem_addr != p_addr || mem_ub_n != p_ub_n || mem_lb_n != p_lb_n ||
                 (mem_dq_oe && mem_dq_out != p_dq)))
                v_stable++;
            if (!mem_ce_n && req_ready) v_ready++;
            if (!mem_oe_n && !mem_we_n) v_excl++;
            if (mem_dq_oe && (mem_we_n || mem_ce_n)) v_drive++;
            if (mem_dq_oe && !p_dq_oe && oe_off < TA_EXP) v_turn++;
            if (mem_oe_n && !p_oe_n && oe_run < RD_EXP) v_rdw++;
            if (mem_we_n && !p_we_n) begin
                if (we_run < WR_EXP) v_wp++;
                if (!p_ce_n) begin
                    logic [15:0] w;
                    w = mget(int'(p_addr));
                    if (!p_lb_n) w[7:0]  = p_dq[7:0];
                    if (!p_ub_n) w[15:8] = p_dq[15:8];
                    model_mem[int'(p_addr)] = w;
                end
            end
        end
        oe_run = (!mem_oe_n && !mem_ce_n) ? oe_run + 1 : 0;
        we_run = (!mem_we_n && !mem_ce_n) ? we_run + 1 : 0;
        oe_off = !mem_oe_n ? 0 : (oe_off < 100 ? oe_off + 1 : oe_off);
        p_ce_n = mem_ce_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe;
        p_ub_n = mem_ub_n; p_lb_n = mem_lb_n; p_addr = mem_addr; p_dq = mem_dq_out;
    end

    // ---------------- scoreboard ----------------
    logic [17:0] exp_q [$];
    logic [15:0] exp_mem [int];

    function automatic logic [15:0] eget(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        logic [15:0] w;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        w = eget(int'(a));
        if (wr) begin
            if (be[0]) w[7:0]  = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            exp_mem[int'(a)] = w;
        end else begin
            exp_q.push_back({be, be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compare each read result with the queued expectation (R2, R3, R8).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected rd_valid", {16'h0, rd_data}, 32'h0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e[15:0], "R2/R3/R8 read data", {16'h0, rd_data}, {16'h0, e[15:0]});
                chk(rd_lanes == e[17:16], "R3 rd_lanes", {30'h0, rd_lanes}, {30'h0, e[17:16]});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            {29'h0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h7);
        chk(mem_ub_n && mem_lb_n, "R1 lane selects high in reset",
            {30'h0, mem_ub_n, mem_lb_n}, 32'h3);
        chk(!mem_dq_oe && !rd_valid, "R1 bus and rd_valid off",
            {30'h0, mem_dq_oe, rd_valid}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        chk(mem_ce_n == 1'b1, "R1 deselected after reset", {31'h0, mem_ce_n}, 32'h1);

        // R4, R2: word write and read.
        access(1, 16'h0010, 16'h1234, 2'b11);
        access(0, 16'h0010, 16'h0000, 2'b11);
        // R3: single-lane writes, then reads of each lane.
        access(1, 16'h0010, 16'hAB55, 2'b01);
        access(0, 16'h0010, 16'h0000, 2'b11);
        access(1, 16'h0010, 16'h99CC, 2'b10);
        access(0, 16'h0010, 16'h0000, 2'b01);
        access(0, 16'h0010, 16'h0000, 2'b10);
        access(0, 16'h0010, 16'h0000, 2'b11);
        // R8: no-lane write leaves data, no-lane read returns zero.
        access(1, 16'h0010, 16'hFFFF, 2'b00);
        access(0, 16'h0010, 16'h0000, 2'b11);
        access(0, 16'h0010, 16'h0000, 2'b00);
        // Address extremes.
        access(1, 16'hFFFF, 16'hBEEF, 2'b11);
        access(1, 16'h0000, 16'h0F0F, 2'b11);
        access(0, 16'hFFFF, 16'h0000, 2'b11);
        access(0, 16'h0000, 16'h0000, 2'b11);
        // R7: reads followed directly by writes, mixed stream.
        lf = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(lf[0], {12'h0, lf[5:2]}, {lf[7:0], lf[15:8]}, lf[9:8]);
        end
        for (int i = 0; i < 16; i++) access(0, 16'(i), 16'h0, 2'b11);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 32'h0);
        chk(v_stable == 0, "R5 pins stable during access", v_stable, 32'h0);
        chk(v_ready == 0, "R6 ready low while selected", v_ready, 32'h0);
        chk(v_turn == 0, "R7 turnaround before drive", v_turn, 32'h0);
        chk(v_drive == 0, "R4 drive only during write strobe", v_drive, 32'h0);
        chk(v_excl == 0, "R9 oe and we never both low", v_excl, 32'h0);
        chk(v_rdw == 0, "R10 read window length", v_rdw, 32'h0);
        chk(v_wp == 0, "R10 write strobe length", v_wp, 32'h0);
        report();
    end

endmodule